// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block shifts or rotates one 32-bit data-path operand by an 8-bit amount and produces the shifted value together with the shifter carry-out that a flag-setting operation would consume. A 2-bit kind input chooses logical left, logical right, arithmetic right or rotate right. An incoming carry flag feeds the cases that keep or rotate in the old carry. The block is purely combinational: the result and carry follow the inputs with no clock.

Amounts are taken literally up to 255. Zero, exactly the word width, and anything larger each have their own result and carry rules per kind. A rotate by zero is reinterpreted as a one-bit rotate right through the carry, and a logical right shift by zero is reinterpreted as a shift by 32. Choosing the operand, decoding immediates and deciding whether flags are written belong to the surrounding data path.

Top module: `barrel_shift_top`

## Requirements
- R1: With kind 00 (logical left) and an amount n from 1 to 31, the result is the operand shifted left by n with zero fill; for n from 1 to 32 the carry-out is operand bit (32 - n).
- R2: With kind 00 and an amount of 0, the result equals the operand and the carry-out equals the incoming carry.
- R3: With kind 00 and an amount of 32 or more, the result is 0; for amounts above 32 the carry-out is 0.
- R4: With kind 01 (logical right) and n from 1 to 31, the result is the operand shifted right by n with zero fill; for n from 1 to 32 the carry-out is operand bit (n - 1), and for n = 32 the result is 0.
- R5: With kind 01 and an amount of 0, the block acts as a shift by 32: the result is 0 and the carry-out is operand bit 31.
- R6: With kind 01 and an amount above 32, the result and the carry-out are both 0.
- R7: With kind 10 (arithmetic right) and n from 1 to 31, the result is the operand shifted right by n with every vacated bit a copy of operand bit 31; the carry-out is operand bit (n - 1).
- R8: With kind 10 and an amount of 0 or of 32 or more, every result bit equals operand bit 31 and the carry-out is operand bit 31.
- R9: With kind 11 (rotate right) and a nonzero amount n, the result is the operand rotated right by (n mod 32) and the carry-out is operand bit ((n + 31) mod 32), which is also result bit 31.
- R10: With kind 11 and an amount of 0, the result is the incoming carry in bit 31 above operand bits 31 to 1, and the carry-out is operand bit 0.
- R11: The kind code is 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right, and the outputs depend only on the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand to be shifted |
| amt_i | input | 8 | Shift amount, 0 to 255 |
| kind_i | input | 2 | Shift kind code (see R11) |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted or rotated operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench goes after the amounts where each kind changes its rule: 0, 1, 31, 32, 33 and 255, with operands whose top and bottom bits differ so that a wrong pick shows. A design that forgot the zero-means-32 rule for logical right would pass the operand through and keep the old carry; one that dropped the rotate-with-extend case would return the operand unchanged instead of pulling the old carry into bit 31. Above 32 a design that folded the amount modulo 32 for the plain shifts would return a nonzero result, and an arithmetic shift that zero-filled past 31 would lose the sign copy. A sweep of every kind over amounts 0 to 40 and 255, with random operands and both carry settings, compares each output against a model written from the rules.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ROR = 2'b11
    } shift_kind_e;

    localparam int unsigned SHF_W  = 32;
    localparam int unsigned SHF_AW = 8;

    typedef struct packed {
        logic [SHF_W-1:0] value;
        logic             carry;
    } shf_out_t;

endpackage

// File: rtl/shf_reverse.sv
module shf_reverse #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign out_o[b] = in_i[W-1-b];
    end
endmodule

// File: rtl/shf_right_core.sv
module shf_right_core #(
    parameter int unsigned W  = 32,
    localparam int unsigned SW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] dist_i,
    input  logic          rotate_i,
    input  logic          fill_i,
    output logic [W-1:0]  data_o
);
    logic [W-1:0] stage_q [SW+1];

    assign stage_q[0] = data_i;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int unsigned SH = 1 << k;
        logic [W-1:0] moved_d;
        logic [SH-1:0] top_d;

        always_comb begin
            if (rotate_i) begin
                top_d = stage_q[k][SH-1:0];
            end else begin
                top_d = {SH{fill_i}};
            end
            moved_d = {top_d, stage_q[k][W-1:SH]};
        end

        assign stage_q[k+1] = dist_i[k] ? moved_d : stage_q[k];
    end

    assign data_o = stage_q[SW];
endmodule

// File: rtl/shf_bit_pick.sv
module shf_bit_pick #(
    parameter int unsigned W  = 32,
    localparam int unsigned SW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] idx_i,
    output logic          bit_o
);
    logic [W-1:0] lvl_q [SW+1];

    assign lvl_q[0] = data_i;

    for (genvar k = 0; k < SW; k++) begin : g_lvl
        localparam int unsigned SH = 1 << k;
        assign lvl_q[k+1] = idx_i[k] ? {{SH{1'b0}}, lvl_q[k][W-1:SH]} : lvl_q[k];
    end

    assign bit_o = lvl_q[SW][0];
endmodule

// File: rtl/barrel_shift_top.sv
module barrel_shift_top
    import shf_pkg::*;
#(
    parameter int unsigned W  = SHF_W,
    parameter int unsigned AW = SHF_AW,
    localparam int unsigned SW = $clog2(W)
) (
    input  logic [W-1:0]  opnd_i,
    input  logic [AW-1:0] amt_i,
    input  logic [1:0]    kind_i,
    input  logic          carry_i,
    output logic [W-1:0]  result_o,
    output logic          carry_o
);
    localparam logic [AW-1:0] AMT_FULL = AW'(W);

    shift_kind_e  kind_d;
    logic [W-1:0] rev_in_d;
    logic [W-1:0] src_d;
    logic [W-1:0] core_d;
    logic [W-1:0] rev_core_d;
    logic [SW-1:0] pick_idx_d;
    logic         pick_bit_d;
    logic         amt_zero_d;
    logic         amt_ge_d;
    logic         amt_gt_d;
    logic         fill_d;
    logic         rotate_d;

    typedef struct packed {
        logic [W-1:0] value;
        logic         carry;
    } out_s;

    out_s out_d;

    assign kind_d     = shift_kind_e'(kind_i);
    assign amt_zero_d = (amt_i == '0);
    assign amt_ge_d   = (amt_i >= AMT_FULL);
    assign amt_gt_d   = (amt_i >  AMT_FULL);
    assign rotate_d   = (kind_d == SHK_ROR);
    assign fill_d     = (kind_d == SHK_ASR) ? opnd_i[W-1] : 1'b0;
    assign pick_idx_d = amt_i[SW-1:0] - SW'(1);

    shf_reverse #(.W(W)) i_rev_in (
        .in_i  (opnd_i),
        .out_o (rev_in_d)
    );

    assign src_d = (kind_d == SHK_LSL) ? rev_in_d : opnd_i;

    shf_right_core #(.W(W)) i_core (
        .data_i   (src_d),
        .dist_i   (amt_i[SW-1:0]),
        .rotate_i (rotate_d),
        .fill_i   (fill_d),
        .data_o   (core_d)
    );

    shf_reverse #(.W(W)) i_rev_out (
        .in_i  (core_d),
        .out_o (rev_core_d)
    );

    shf_bit_pick #(.W(W)) i_pick (
        .data_i (src_d),
        .idx_i  (pick_idx_d),
        .bit_o  (pick_bit_d)
    );

    always_comb begin
        out_d = '0;
        unique case (kind_d)
            SHK_LSL: begin
                out_d.value = amt_ge_d ? '0 : rev_core_d;
                if (amt_zero_d) begin
                    out_d.carry = carry_i;
                end else if (amt_gt_d) begin
                    out_d.carry = 1'b0;
                end else begin
                    out_d.carry = pick_bit_d;
                end
            end
            SHK_LSR: begin
                out_d.value = (amt_zero_d || amt_ge_d) ? '0 : core_d;
                if (amt_zero_d) begin
                    out_d.carry = opnd_i[W-1];
                end else if (amt_gt_d) begin
                    out_d.carry = 1'b0;
                end else begin
                    out_d.carry = pick_bit_d;
                end
            end
            SHK_ASR: begin
                if (amt_zero_d || amt_ge_d) begin
                    out_d.value = {W{opnd_i[W-1]}};
                    out_d.carry = opnd_i[W-1];
                end else begin
                    out_d.value = core_d;
                    out_d.carry = pick_bit_d;
                end
            end
            SHK_ROR: begin
                if (amt_zero_d) begin
                    out_d.value = {carry_i, opnd_i[W-1:1]};
                    out_d.carry = opnd_i[0];
                end else begin
                    out_d.value = core_d;
                    out_d.carry = pick_bit_d;
                end
            end
            default: out_d = '0;
        endcase
    end

    assign result_o = out_d.value;
    assign carry_o  = out_d.carry;
endmodule

// File: rtl/shf_checker.sv
module shf_checker #(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 8
) (
    input logic [W-1:0]  opnd_i,
    input logic [AW-1:0] amt_i,
    input logic [1:0]    kind_i,
    input logic          carry_i,
    input logic [W-1:0]  result_o,
    input logic          carry_o
);
    localparam int unsigned FULL = W;

    always_comb begin
        if (!$isunknown({opnd_i, amt_i, kind_i, carry_i})) begin
            if (kind_i == 2'b00 && amt_i == '0) begin
                assert_lsl_zero_R2: assert (result_o == opnd_i && carry_o == carry_i)
                    else $error("R2 logical left by zero altered operand or carry");
            end
            if (kind_i == 2'b00 && int'(amt_i) > FULL) begin
                assert_lsl_big_R3: assert (result_o == '0 && carry_o == 1'b0)
                    else $error("R3 logical left above width not cleared");
            end
            if (kind_i == 2'b00 && int'(amt_i) >= 1 && int'(amt_i) <= FULL) begin
                assert_lsl_carry_R1: assert (carry_o == opnd_i[FULL - int'(amt_i)])
                    else $error("R1 logical left carry wrong");
            end
            if (kind_i == 2'b01 && amt_i == '0) begin
                assert_lsr_zero_R5: assert (result_o == '0 && carry_o == opnd_i[W-1])
                    else $error("R5 logical right by zero not treated as full width");
            end
            if (kind_i == 2'b01 && int'(amt_i) > FULL) begin
                assert_lsr_big_R6: assert (result_o == '0 && carry_o == 1'b0)
                    else $error("R6 logical right above width not cleared");
            end
            if (kind_i == 2'b10 && (amt_i == '0 || int'(amt_i) >= FULL)) begin
                assert_asr_sat_R8: assert (result_o == {W{opnd_i[W-1]}} && carry_o == opnd_i[W-1])
                    else $error("R8 arithmetic right saturation wrong");
            end
            if (kind_i == 2'b11 && amt_i != '0) begin
                assert_ror_carry_R9: assert (carry_o == result_o[W-1])
                    else $error("R9 rotate carry does not match top result bit");
            end
            if (kind_i == 2'b11 && amt_i == '0) begin
                assert_rrx_R10: assert (result_o == {carry_i, opnd_i[W-1:1]} && carry_o == opnd_i[0])
                    else $error("R10 rotate through carry wrong");
            end
        end
    end
endmodule

bind barrel_shift_top shf_checker #(.W(W), .AW(AW)) i_shf_checker (
    .opnd_i   (opnd_i),
    .amt_i    (amt_i),
    .kind_i   (kind_i),
    .carry_i  (carry_i),
    .result_o (result_o),
    .carry_o  (carry_o)
);

// File: tb/test_barrel_shift_top.sv
module test_barrel_shift_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd;
    logic [7:0]  amt;
    logic [1:0]  kind;
    logic        cin;
    logic [31:0] result;
    logic        cout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    barrel_shift_top i_barrel_shift_top (
        .opnd_i   (opnd),
        .amt_i    (amt),
        .kind_i   (kind),
        .carry_i  (cin),
        .result_o (result),
        .carry_o  (cout)
    );

    task automatic model(input logic [1:0] k, input logic [31:0] v, input int n,
                         input logic ci, output logic [31:0] r, output logic c);
        int m;
        case (k)
            2'b00: begin
                if (n == 0) begin r = v; c = ci; end
                else if (n < 32) begin r = v << n; c = v[32-n]; end
                else if (n == 32) begin r = '0; c = v[0]; end
                else begin r = '0; c = 1'b0; end
            end
            2'b01: begin
                if (n == 0 || n == 32) begin r = '0; c = v[31]; end
                else if (n < 32) begin r = v >> n; c = v[n-1]; end
                else begin r = '0; c = 1'b0; end
            end
            2'b10: begin
                if (n == 0 || n >= 32) begin r = {32{v[31]}}; c = v[31]; end
                else begin r = 32'($signed(v) >>> n); c = v[n-1]; end
            end
            default: begin
                if (n == 0) begin r = {ci, v[31:1]}; c = v[0]; end
                else begin
                    m = n % 32;
                    r = (m == 0) ? v : ((v >> m) | (v << (32 - m)));
                    c = v[(n + 31) % 32];
                end
            end
        endcase
    endtask

    task automatic apply_check(input string tag, input logic [1:0] k, input logic [31:0] v,
                               input int n, input logic ci);
        logic [31:0] er;
        logic        ec;
        @(negedge clk);
        kind = k; opnd = v; amt = 8'(n); cin = ci;
        #1;
        model(k, v, n, ci, er, ec);
        checks++;
        if (result !== er || cout !== ec) begin
            errors++;
            $display("FAIL %s kind=%0d amt=%0d opnd=%h cin=%0b: got %h/%0b expected %h/%0b",
                     tag, k, n, v, ci, result, cout, er, ec);
        end
    endtask

    task automatic t_reset;
        logic [31:0] er;
        logic        ec;
        @(negedge clk);
        #1;
        model(2'b00, 32'h0, 0, 1'b0, er, ec);
        checks++;
        if (result !== er || cout !== ec) begin
            errors++;
            $display("FAIL R11 idle state: got %h/%0b expected %h/%0b", result, cout, er, ec);
        end
    endtask

    task automatic t_lsl;
        apply_check("R1", 2'b00, 32'h8000_0001, 1, 1'b0);
        apply_check("R1", 2'b00, 32'h4000_0003, 31, 1'b0);
        apply_check("R1", 2'b00, 32'h0000_0001, 32, 1'b0);
        apply_check("R2", 2'b00, 32'hA5A5_0F0F, 0, 1'b1);
        apply_check("R2", 2'b00, 32'hA5A5_0F0F, 0, 1'b0);
        apply_check("R3", 2'b00, 32'hFFFF_FFFF, 33, 1'b1);
        apply_check("R3", 2'b00, 32'hFFFF_FFFF, 255, 1'b1);
    endtask

    task automatic t_lsr;
        apply_check("R4", 2'b01, 32'h8000_0001, 1, 1'b0);
        apply_check("R4", 2'b01, 32'h8000_0000, 32, 1'b0);
        apply_check("R4", 2'b01, 32'hC000_0000, 31, 1'b0);
        apply_check("R5", 2'b01, 32'h8000_0000, 0, 1'b0);
        apply_check("R5", 2'b01, 32'h7FFF_FFFF, 0, 1'b1);
        apply_check("R6", 2'b01, 32'hFFFF_FFFF, 33, 1'b1);
        apply_check("R6", 2'b01, 32'hFFFF_FFFF, 200, 1'b1);
    endtask

    task automatic t_asr;
        apply_check("R7", 2'b10, 32'h8000_0002, 1, 1'b0);
        apply_check("R7", 2'b10, 32'h4000_0000, 31, 1'b1);
        apply_check("R8", 2'b10, 32'h8000_0000, 0, 1'b0);
        apply_check("R8", 2'b10, 32'h7FFF_FFFF, 32, 1'b1);
        apply_check("R8", 2'b10, 32'h8000_0001, 40, 1'b0);
    endtask

    task automatic t_ror;
        apply_check("R9", 2'b11, 32'h0000_0001, 1, 1'b0);
        apply_check("R9", 2'b11, 32'h1234_5678, 32, 1'b0);
        apply_check("R9", 2'b11, 32'h1234_5679, 33, 1'b0);
        apply_check("R9", 2'b11, 32'h8765_4321, 255, 1'b0);
        apply_check("R10", 2'b11, 32'h0000_0003, 0, 1'b1);
        apply_check("R10", 2'b11, 32'hFFFF_FFFE, 0, 1'b0);
    endtask

    task automatic t_sweep;
        for (int k = 0; k < 4; k++) begin
            for (int n = 0; n <= 41; n++) begin
                int na;
                na = (n == 41) ? 255 : n;
                for (int t = 0; t < 4; t++) begin
                    logic [31:0] v;
                    v = $urandom();
                    if (t == 0) v[31] = 1'b1;
                    if (t == 1) v[31] = 1'b0;
                    apply_check("R11", 2'(k), v, na, t[0]);
                end
            end
        end
    endtask

    initial begin
        opnd = '0; amt = '0; kind = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset();
        t_lsl();
        t_lsr();
        t_asr();
        t_ror();
        t_sweep();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired before all checks ran");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule